// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer. An 8-bit prescaler divides a qualifying tick input. The divided steps drive a counter that is 24 bits wide by default. The counter is compared with a programmable value. On equality the block raises a sticky time-out flag and applies the action of the selected mode:

- **One-shot**: stop.
- **Periodic**: restart.
- **Toggle**: restart and invert an output pin.
- **Continuous**: keep counting and wrap at the top of the count range.

Software reaches the block through a small word-addressed register port with four registers:

| Address | Register | Fields |
|---|---|---|
| 0 | Control | prescale `[7:0]`, mode `[9:8]`, run request `[12]`, interrupt enable `[13]`, counter-reset command `[14]`, active status `[15]` (read-only) |
| 1 | Compare value | compare value in the low bits |
| 2 | Status | time-out flag `[0]` |
| 3 | Count | current count (read-only) |

Mode codes: 0 = one-shot, 1 = periodic, 2 = toggle, 3 = continuous.

Writes take effect at the clock edge on which `wr_en` is high. Reads return `rdata` combinationally for the current `addr`.

The timer clock is the system clock qualified by `tick_en`. Every timer action that counts timer clocks advances only on edges where `tick_en` is 1. The run request passes through a two-tick handshake before counting starts or stops. The active-status bit reports when that handshake has completed.

Top module: `presc_cmp_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 at addresses 0 to 3, and `irq`, `tgl_out` and `active` are 0.
- R2: While `active` is 1, the counter (address 3) advances by one on every (prescale+1)-th edge with `tick_en` high, where the prescale value is control bits [7:0]. While `active` is 0, the count holds unless a register write clears it.
- R3: The time-out flag (status bit 0) is set on the step that makes the count equal the compare value. Writing 1 to status bit 0 clears the flag. When a match and that clear fall on the same edge, the flag stays 1.
- R4: In one-shot mode (mode 0), a match clears the count, clears the run request (control bit 12) and drops `active` on the same edge.
- R5: In periodic mode (mode 1), a match clears the count and counting goes on.
- R6: In toggle mode (mode 2), a match clears the count and inverts `tgl_out`. `tgl_out` changes in no other mode.
- R7: In continuous mode (mode 3), a match leaves the count running. The count wraps from all-ones to 0.
- R8: Writing the compare register (address 1) clears the prescale counter and the count in modes 0, 1 and 2. In mode 3 the same write leaves both untouched.
- R9: `active` (also control bit 15) copies the run request after two edges with `tick_en` high.
- R10: A control write with bit 14 set clears both counters. If `active` was 1, that write also clears the run request and `active` at once. Bit 14 always reads 0.
- R11: A control write whose prescale field differs from the stored value clears the prescale counter and the count.
- R12: `irq` is 1 exactly when the time-out flag and the interrupt enable (control bit 13) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock qualifier; one timer clock per high edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Time-out interrupt |
| tgl_out | output | 1 | Toggle-mode output |
| active | output | 1 | Handshake-complete run status |

## Verification
The two functions that can collide are a time-out match setting the flag and a software write-one clearing it on the same edge. The bench holds a status clear write asserted for many consecutive cycles while a periodic timer runs, so that several matches land under an active clear. The per-cycle reference model expects the flag to read 1 on the cycle after each match and 0 on the following cycle. Compare and control writes that land on a counting step are provoked the same way, and each is judged by the rule that the clearing write overrides the step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_TOGGLE   = 2'd2,
        MODE_CONT     = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    localparam int BIT_MODE_LO = 8;
    localparam int BIT_RUN     = 12;
    localparam int BIT_IE      = 13;
    localparam int BIT_CRST    = 14;
    localparam int BIT_ACT     = 15;
    localparam int PSC_FIELD_W = 8;

    typedef struct packed {
        logic [PSC_FIELD_W-1:0] psc;
        tmr_mode_e              mode;
        logic                   run;
        logic                   ie;
    } tmr_ctl_t;

    function automatic logic [31:0] ctl_to_word(tmr_ctl_t c, logic act);
        logic [31:0] w;
        w = '0;
        w[PSC_FIELD_W-1:0]           = c.psc;
        w[BIT_MODE_LO+1:BIT_MODE_LO] = c.mode;
        w[BIT_RUN]                   = c.run;
        w[BIT_IE]                    = c.ie;
        w[BIT_ACT]                   = act;
        return w;
    endfunction

    function automatic logic restarts_on_cmp_write(tmr_mode_e m);
        return m != MODE_CONT;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic [PSC_W-1:0] div,
    output logic             step
);
    logic [PSC_W-1:0] pcnt;
    logic             at_end;

    assign at_end = (pcnt == div);
    assign step   = en && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (en) begin
            pcnt <= at_end ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_enable_sync.sv
module tmr_enable_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  logic force_off,
    output logic active
);
    logic [SYNC_N-1:0] stage;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst || force_off) stage <= '0;
                else if (tick)        stage <= req;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst || force_off) stage <= '0;
                else if (tick)        stage <= {stage[SYNC_N-2:0], req};
            end
        end
    endgenerate

    assign active = stage[SYNC_N-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             tgl
);
    logic [CNT_W-1:0] nxt;
    logic             hit;

    assign nxt   = cnt + 1'b1;
    assign hit   = (nxt == cmp);
    assign match = step && hit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (hit && mode != MODE_CONT) ? '0 : nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                              tgl <= 1'b0;
        else if (match && mode == MODE_TOGGLE) tgl <= ~tgl;
    end
endmodule

// File: rtl/presc_cmp_timer.sv
module presc_cmp_timer
    import tmr_pkg::*;
#(
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 24,
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        tgl_out,
    output logic        active
);
    localparam int PAD_W = PSC_FIELD_W - PSC_W;

    tmr_ctl_t         ctl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;
    logic [CNT_W-1:0] cnt;
    logic             match;
    logic             step;
    logic             wr_ctl, wr_cmp, wr_stat;
    logic             crst_cmd, psc_chg, cnt_clr, force_off;
    logic [PSC_FIELD_W-1:0] new_psc;

    assign wr_ctl  = wr_en && (addr == ADDR_CTL);
    assign wr_cmp  = wr_en && (addr == ADDR_CMP);
    assign wr_stat = wr_en && (addr == ADDR_STAT);

    assign new_psc  = {{PAD_W{1'b0}}, wdata[PSC_W-1:0]};
    assign crst_cmd = wr_ctl && wdata[BIT_CRST];
    assign psc_chg  = wr_ctl && (new_psc != ctl_q.psc);
    assign cnt_clr  = psc_chg || crst_cmd ||
                      (wr_cmp && restarts_on_cmp_write(ctl_q.mode));
    assign force_off = (crst_cmd && active) ||
                       (match && ctl_q.mode == MODE_ONESHOT);

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .en   (active && tick_en),
        .clr  (cnt_clr),
        .div  (ctl_q.psc[PSC_W-1:0]),
        .step (step)
    );

    tmr_enable_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .req       (ctl_q.run),
        .force_off (force_off),
        .active    (active)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .clr   (cnt_clr),
        .mode  (ctl_q.mode),
        .cmp   (cmp_q),
        .cnt   (cnt),
        .match (match),
        .tgl   (tgl_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (match && ctl_q.mode == MODE_ONESHOT) ctl_q.run <= 1'b0;
            if (wr_ctl) begin
                ctl_q.psc  <= new_psc;
                ctl_q.mode <= tmr_mode_e'(wdata[BIT_MODE_LO+1:BIT_MODE_LO]);
                ctl_q.ie   <= wdata[BIT_IE];
                ctl_q.run  <= (wdata[BIT_CRST] && active) ? 1'b0 : wdata[BIT_RUN];
            end
            if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
            if (match)                     flag_q <= 1'b1;
            else if (wr_stat && wdata[0])  flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && ctl_q.ie;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTL:  rdata = ctl_to_word(ctl_q, active);
            ADDR_CMP:  rdata[CNT_W-1:0] = cmp_q;
            ADDR_STAT: rdata[0] = flag_q;
            default:   rdata[CNT_W-1:0] = cnt;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic             active,
    input logic             run,
    input logic             match,
    input logic             flag,
    input tmr_mode_e        mode,
    input logic [CNT_W-1:0] cnt,
    input logic             tgl_out
);
    // R2: an idle timer with no register write keeps its count
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!active && !wr_en) |=> $stable(cnt));

    // R3: the flag only falls through a write-one clear
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && addr == ADDR_STAT && wdata[0])) |=> flag);

    // R4: a one-shot match halts the timer on the next edge
    p_oneshot_halt_r4: assert property (@(posedge clk) disable iff (rst)
        (match && mode == MODE_ONESHOT && !wr_en) |=> (!run && !active && cnt == '0));

    // R6: the toggle pin moves only while toggle mode is selected
    p_tgl_mode_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgl_out) |-> $past(mode) == MODE_TOGGLE);

    // R9: active can only rise on a timer clock
    p_active_tick_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(tick_en));
endmodule

bind presc_cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .active  (active),
    .run     (ctl_q.run),
    .match   (match),
    .flag    (flag_q),
    .mode    (ctl_q.mode),
    .cnt     (cnt),
    .tgl_out (tgl_out)
);

// File: tb/presc_cmp_timer_test.sv
module presc_cmp_timer_test;
    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, tgl_out, active;

    int    checks = 0;
    int    bad = 0;
    int    cycles = 0;
    int    tk = 0;
    bit    sparse = 0;
    string cur_req = "R1";

    // reference state
    int m_psc, m_mode, m_run, m_ie, m_cmp, m_flag, m_pcnt, m_cnt, m_tgl;
    int hs[$];

    always #10 clk = ~clk;

    presc_cmp_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .tgl_out(tgl_out), .active(active)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_active();
        return hs[1];
    endfunction

    function automatic logic [31:0] m_read(logic [1:0] a);
        case (a)
            2'd0: return 32'((m_active() << 15) | (m_ie << 13) | (m_run << 12) | (m_mode << 8) | m_psc);
            2'd1: return 32'(m_cmp);
            2'd2: return 32'(m_flag);
            default: return 32'(m_cnt);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psc = 0; m_mode = 0; m_run = 0; m_ie = 0; m_cmp = 0;
            m_flag = 0; m_pcnt = 0; m_cnt = 0; m_tgl = 0;
            hs = '{0, 0};
        end else begin
            int  act, stp, hit, clr, off, n_run, n_pcnt, n_cnt;
            act = m_active();
            stp = (act != 0) && tick_en && (m_pcnt == m_psc);
            hit = stp && (((m_cnt + 1) & MASK) == m_cmp);
            n_pcnt = (act != 0 && tick_en) ? ((m_pcnt == m_psc) ? 0 : m_pcnt + 1) : m_pcnt;
            n_cnt  = stp ? ((hit && m_mode != 3) ? 0 : ((m_cnt + 1) & MASK)) : m_cnt;
            if (hit && m_mode == 2) m_tgl = 1 - m_tgl;
            if (hit) m_flag = 1;
            else if (wr_en && addr == 2 && wdata[0]) m_flag = 0;
            n_run = m_run;
            off = 0;
            clr = 0;
            if (hit && m_mode == 0) begin n_run = 0; off = 1; end
            if (wr_en && addr == 0) begin
                if (int'(wdata[7:0]) != m_psc || wdata[14]) clr = 1;
                m_psc = int'(wdata[7:0]);
                m_ie  = int'(wdata[13]);
                if (wdata[14] && act != 0) begin n_run = 0; off = 1; end
                else n_run = int'(wdata[12]);
                m_mode_upd: m_mode = int'(wdata[9:8]);
            end
            if (wr_en && addr == 1) begin
                if (m_mode_prev_not_cont(hit)) clr = 1;
                m_cmp = int'(wdata[CW-1:0]);
            end
            if (clr) begin n_pcnt = 0; n_cnt = 0; end
            if (off) hs = '{0, 0};
            else if (tick_en) hs = '{m_run, hs[0]};
            m_pcnt = n_pcnt;
            m_cnt  = n_cnt;
            m_run  = n_run;
        end
    end

    // compare writes see the mode stored before this edge; control and
    // compare writes never share an edge in this bench
    function automatic bit m_mode_prev_not_cont(int unused_hit);
        return (m_mode != 3) || (unused_hit < 0);
    endfunction

    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            check(cur_req, "rdata", rdata, m_read(addr));
            check("R12", "irq", {31'd0, irq}, 32'((m_flag != 0) && (m_ie != 0)));
            check("R6", "tgl_out", {31'd0, tgl_out}, 32'(m_tgl));
            check("R9", "active", {31'd0, active}, 32'(m_active()));
        end
    end

    always @(negedge clk) begin
        tk++;
        tick_en <= sparse ? (tk % 3 == 0) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, string req, string what, logic [31:0] exp);
        addr = a;
        #1;
        check(req, what, rdata, exp);
    endtask

    localparam logic [31:0] RUN = 32'h1000;
    localparam logic [31:0] IE  = 32'h2000;
    localparam logic [31:0] CRS = 32'h4000;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a < 4; a++) peek(2'(a), "R1", "reset reg", 32'd0);
        check("R1", "outs", {29'd0, irq, tgl_out, active}, 32'd0);

        // R9 handshake, periodic run (R5)
        cur_req = "R5";
        wr(2'd1, 32'd5);
        wr(2'd0, IE | RUN | 32'h100 | 32'd2);
        check("R9", "active after write", {31'd0, active}, 32'd0);
        @(negedge clk);
        check("R9", "active after one tick", {31'd0, active}, 32'd0);
        @(negedge clk);
        check("R9", "active after two ticks", {31'd0, active}, 32'd1);
        addr = 2'd3;
        repeat (60) @(negedge clk);
        peek(2'd2, "R3", "flag after matches", 32'd1);
        wr(2'd2, 32'd1);
        peek(2'd2, "R3", "flag after clear", 32'd0);

        // R3 collision: clear held across several matches
        cur_req = "R3";
        wr_en = 1'b1; addr = 2'd2; wdata = 32'd1;
        repeat (40) @(negedge clk);
        wr_en = 1'b0;
        repeat (5) @(negedge clk);

        // R2 sparse timer clock
        cur_req = "R2";
        sparse = 1;
        addr = 2'd3;
        repeat (90) @(negedge clk);
        sparse = 0;

        // R11 prescale change clears count
        wr(2'd0, IE | RUN | 32'h100 | 32'd0);
        peek(2'd3, "R11", "count after prescale change", 32'd0);
        cur_req = "R11";
        repeat (10) @(negedge clk);

        // R6 toggle mode
        cur_req = "R6";
        wr(2'd0, IE | RUN | 32'h200 | 32'd0);
        addr = 2'd3;
        repeat (50) @(negedge clk);

        // R8 compare rewrite restarts in toggle mode
        wr(2'd1, 32'd9);
        peek(2'd3, "R8", "count after compare write", 32'd0);
        cur_req = "R8";
        repeat (30) @(negedge clk);

        // R7 continuous with compare rewrite and wrap
        wr(2'd0, RUN | 32'h300 | 32'd0);
        repeat (7) @(negedge clk);
        wr(2'd1, 32'd3);
        cur_req = "R7";
        addr = 2'd3;
        repeat (1100) @(negedge clk);
        peek(2'd2, "R7", "flag after wrap", 32'd1);

        // R4 one-shot
        wr(2'd1, 32'd4);
        cur_req = "R4";
        wr(2'd0, IE | RUN | 32'h000 | 32'd1);
        repeat (30) @(negedge clk);
        peek(2'd0, "R4", "control after one-shot", IE | 32'd1);
        peek(2'd3, "R4", "count after one-shot", 32'd0);

        // R10 counter reset command
        cur_req = "R10";
        wr(2'd0, RUN | 32'h100 | 32'd1);
        repeat (20) @(negedge clk);
        wr(2'd0, CRS | RUN | 32'h100 | 32'd1);
        peek(2'd0, "R10", "control after reset cmd", 32'h100 | 32'd1);
        peek(2'd3, "R10", "count after reset cmd", 32'd0);
        repeat (10) @(negedge clk);
        peek(2'd3, "R10", "count stays idle", 32'd0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule